// File: doc/BRIEF.md
# Ten-to-Four Lane Transmit Gearbox

This block repacks ten slow serial input lanes into four fast output lanes. It is a cycle-level digital model in which one clock cycle is one output bit time. Over a ten-cycle superframe, each input lane supplies four bits, taken at fixed cycles of the superframe. Each output lane emits ten bits in the same superframe. An output lane therefore carries two and a half times the bit rate of an input lane.

The datapath is made of two identical halves. Each half takes five input lanes and drives two output lanes. Inside a half, every input lane is split four ways into sub-stream slots. The slots are moved as one parallel word into a hold register at the end of the superframe. Four five-to-one multiplexers then read the hold register, each steered by one phase of a one-hot five-phase ring that advances every second cycle. A full-rate two-to-one stage takes the multiplexers in pairs and alternates between them on each cycle to form an output lane. A strobe shows the upstream logic the cycles in which the input lanes are sampled. A marker shows which output cycle carries the first bit of a superframe.

Top module: `gbx_tx_10to4`

## Requirements
- R1: `take_o` is high exactly in cycles 0, 3, 5 and 8 of each ten-cycle superframe. Cycle 0 is the first cycle after synchronous reset is released. In those cycles the input lanes are sampled as sample numbers 0, 1, 2 and 3 of that superframe.
- R2: For half 0, output lane j (j = 0 or 1) at superframe position c (0..9) carries sample number 2j + (c mod 2) of input lane floor(c/2), taken in the previous superframe.
- R3: Half 1 maps input lanes 5..9 to output lanes 2..3 with the same rule, with the lane index offset by 5.
- R4: Each output bit is registered. The bit for position c appears on the outputs in the cycle after superframe cycle c. `word_start_o` is high exactly in the cycles in which the outputs carry position 0.
- R5: Synchronous reset clears all outputs and data registers, and sets the sequencer to superframe cycle 0. The output bits of the first superframe after reset are all zero.
- R6: Each half's multiplexer select is one-hot in every cycle after reset. It changes only after the second cycle of a pair.
- R7: Input lane values in cycles where `take_o` is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lanes_i | input | 10 | One bit per slow input lane, sampled when `take_o` is high |
| lanes_o | output | 4 | One bit per fast output lane |
| take_o | output | 1 | High in the cycles in which `lanes_i` is sampled |
| word_start_o | output | 1 | High while `lanes_o` carries superframe position 0 |

## Verification
The assertions assume only that reset is held high from time zero until the first edge. After that, the sequencer's own state drives every checked relation, and the lane data may take any value. The stimulus drives new lane words only in the cycles announced by `take_o`. It drives random values in the other cycles, so that any leak of unsampled data shows on the outputs. The words follow four patterns in turn: random, all ones, a walking one and alternating bits. A second reset in the middle of the run exercises the restart.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
    // Lanes served by one half and the output lanes it drives
    localparam int HALF_IN  = 5;
    localparam int HALF_OUT = 2;
    // Sub-stream slots per input lane (two multiplexers per output lane)
    localparam int SUBS     = 2 * HALF_OUT;
    // Superframe length in output bit times
    localparam int FRAME    = 2 * HALF_IN;
    localparam int SLOT_W   = $clog2(SUBS);
    localparam int CYC_W    = $clog2(FRAME);

    typedef logic [SUBS-1:0]             sub_vec_t;
    typedef logic [HALF_IN-1:0][SUBS-1:0] slot_word_t;
endpackage

// File: rtl/gbx_phase_seq.sv
module gbx_phase_seq
    import gbx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [HALF_IN-1:0] phase_o,
    output logic              odd_o,
    output logic              take_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              load_o,
    output logic              start_o
);
    typedef struct packed {
        logic [HALF_IN-1:0] ring;
        logic               odd;
    } seq_t;

    seq_t st_d, st_q;
    logic [CYC_W-1:0] cyc_w;

    // Next state: ring shifts with NOR refill on the odd cycle of each pair
    always_comb begin
        st_d = st_q;
        st_d.odd = ~st_q.odd;
        if (st_q.odd) begin
            st_d.ring = {st_q.ring[HALF_IN-2:0], ~|st_q.ring[HALF_IN-2:0]};
        end
    end

    // Decode superframe position and sampling slot
    always_comb begin
        cyc_w  = '0;
        take_o = 1'b0;
        slot_o = '0;
        for (int p = 0; p < HALF_IN; p++) begin
            if (st_q.ring[p]) cyc_w = CYC_W'(2 * p) + CYC_W'(st_q.odd);
        end
        for (int k = 0; k < SUBS; k++) begin
            if (cyc_w == CYC_W'((k * FRAME + SUBS - 1) / SUBS)) begin
                take_o = 1'b1;
                slot_o = SLOT_W'(k);
            end
        end
    end

    assign phase_o = st_q.ring;
    assign odd_o   = st_q.odd;
    assign load_o  = st_q.ring[HALF_IN-1] & st_q.odd;
    assign start_o = st_q.ring[0] & ~st_q.odd;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.ring <= HALF_IN'(1);
            st_q.odd  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    ring_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(st_q.ring));
    // R6
    ring_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.odd |=> $stable(st_q.ring));
    // R1
    take_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |=> !take_o);
endmodule

// File: rtl/gbx_half.sv
module gbx_half
    import gbx_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [HALF_IN-1:0] lanes_i,
    input  logic               take_i,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic               load_i,
    input  logic [HALF_IN-1:0] phase_i,
    input  logic               odd_i,
    output logic [HALF_OUT-1:0] lanes_o
);
    typedef struct packed {
        slot_word_t          cap;
        slot_word_t          hold;
        logic [HALF_OUT-1:0] out;
    } half_t;

    half_t    st_d, st_q;
    sub_vec_t mux_w;

    // Five-to-one AND-OR multiplexers, one per sub-stream slot
    always_comb begin
        mux_w = '0;
        for (int m = 0; m < SUBS; m++) begin
            for (int i = 0; i < HALF_IN; i++) begin
                mux_w[m] = mux_w[m] | (phase_i[i] & st_q.hold[i][m]);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        // One-to-four split: each sampled bit goes to its slot
        if (take_i) begin
            for (int i = 0; i < HALF_IN; i++) begin
                st_d.cap[i][slot_i] = lanes_i[i];
            end
        end
        if (load_i) st_d.hold = st_q.cap;
        // Full-rate interleave of multiplexer pairs
        for (int j = 0; j < HALF_OUT; j++) begin
            st_d.out[j] = odd_i ? mux_w[2*j+1] : mux_w[2*j];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign lanes_o = st_q.out;

    // R6
    phase_sel_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(phase_i));
    // R4
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(st_q.hold));
    // R7
    cap_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !take_i |=> $stable(st_q.cap));
endmodule

// File: rtl/gbx_tx_10to4.sv
module gbx_tx_10to4
    import gbx_pkg::*;
#(
    parameter int NUM_HALVES = 2
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic [NUM_HALVES*HALF_IN-1:0]  lanes_i,
    output logic [NUM_HALVES*HALF_OUT-1:0] lanes_o,
    output logic                           take_o,
    output logic                           word_start_o
);
    typedef struct packed {
        logic start;
    } top_t;

    top_t st_d, st_q;

    logic [HALF_IN-1:0] phase_w;
    logic               odd_w;
    logic [SLOT_W-1:0]  slot_w;
    logic               load_w;
    logic               start_w;

    gbx_phase_seq seq_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .phase_o (phase_w),
        .odd_o   (odd_w),
        .take_o  (take_o),
        .slot_o  (slot_w),
        .load_o  (load_w),
        .start_o (start_w)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        gbx_half half_i (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .lanes_i (lanes_i[h*HALF_IN +: HALF_IN]),
            .take_i  (take_o),
            .slot_i  (slot_w),
            .load_i  (load_w),
            .phase_i (phase_w),
            .odd_i   (odd_w),
            .lanes_o (lanes_o[h*HALF_OUT +: HALF_OUT])
        );
    end

    // Marker aligned with the registered output bits
    always_comb begin
        st_d.start = start_w;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign word_start_o = st_q.start;

    // R4
    start_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        word_start_o |=> !word_start_o);
    // R1
    take_at_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_w |-> take_o);
endmodule

// File: tb/gbx_tx_10to4_tb_top.sv
module gbx_tx_10to4_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] lanes = '0;
    logic [3:0] lanes_o;
    logic       take, start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit [3:0] samp [0:63][0:9];

    always #4 clk = ~clk;

    gbx_tx_10to4 dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .lanes_i      (lanes),
        .lanes_o      (lanes_o),
        .take_o       (take),
        .word_start_o (start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: sample number for each superframe cycle, -1 when not sampled
    function automatic int slot_of(input int c);
        case (c)
            0: return 0;
            3: return 1;
            5: return 2;
            8: return 3;
            default: return -1;
        endcase
    endfunction

    // R2/R3/R5: expected output bit
    function automatic bit exp_bit(input int sf, input int c, input int o);
        int h, j;
        h = o / 2;
        j = o % 2;
        if (sf == 0) return 1'b0;
        return samp[sf-1][5*h + c/2][2*j + c%2];
    endfunction

    function automatic logic [9:0] gen_word(input int sf, input int k);
        case (sf % 4)
            0: return 10'($urandom);
            1: return 10'h3FF;
            2: return 10'(1 << ((sf + k) % 10));
            default: return (k % 2 == 0) ? 10'h155 : 10'h2AA;
        endcase
    endfunction

    task automatic clear_samp();
        for (int s = 0; s < 64; s++)
            for (int l = 0; l < 10; l++)
                samp[s][l] = '0;
    endtask

    task automatic run(input int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            int k;
            logic [9:0] w;
            if (n > 0) begin
                int m, sf, c;
                @(negedge clk);
                m  = n - 1;
                sf = m / 10;
                c  = m % 10;
                for (int o = 0; o < 4; o++) begin
                    bit e;
                    e = exp_bit(sf, c, o);
                    chk(lanes_o[o] === e, (sf == 0) ? "R5" : ((o < 2) ? "R2" : "R3"),
                        int'(lanes_o[o]), int'(e));
                end
                chk(start === (c == 0), "R4", int'(start), int'(c == 0));
            end
            chk(take === (slot_of(n % 10) >= 0), "R1", int'(take), int'(slot_of(n % 10) >= 0));
            k = slot_of(n % 10);
            if (k >= 0) begin
                w = gen_word(n / 10, k);
                lanes = w;
                for (int l = 0; l < 10; l++) samp[n/10][l][k] = w[l];
            end else begin
                lanes = 10'($urandom); // R7: unsampled noise
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        clear_samp();
        repeat (3) @(negedge clk);
        chk(lanes_o === 4'b0, "R5", int'(lanes_o), 0);
        chk(start === 1'b0, "R5", int'(start), 0);
        rst = 1'b0;
        run(300);

        // Mid-run reset restarts the superframe
        rst = 1'b1;
        lanes = 10'($urandom);
        @(negedge clk);
        @(negedge clk);
        chk(lanes_o === 4'b0, "R5", int'(lanes_o), 0);
        chk(start === 1'b0, "R5", int'(start), 0);
        clear_samp();
        rst = 1'b0;
        run(300);
        finish_run();
    end
endmodule